// File: doc/BRIEF.md
# Timer Counter with Repeat and One-Shot Modes

This block is the 16-bit up-counter at the heart of a timer. It advances by one on each cycle where a count-enable pulse arrives while the counter is running. The count-enable pulse takes the place of a prescaled clock. A period value sets where the count returns to zero. A software clear strobe forces the count to zero at any time. A mode input chooses between two behaviours. In repeat mode the counter runs until software stops it. In one-shot mode the counter halts by itself when it is cleared or when it wraps.

The run state is held by a two-state machine. `IDLE` is the state after reset, and no counting happens in it. `RUN` is the state in which counting happens. There are three transitions:
- `START`: from `IDLE` to `RUN` on a start pulse that comes without a stop pulse.
- `STOP`: from `RUN` to `IDLE` on a stop pulse.
- `ONESHOT_END`: from `RUN` to `IDLE` in one-shot mode, on a clear strobe or on a period-match or overflow event.

The block reports the count, the run state, and one-cycle pulses for period match and overflow.

Top module: `tmr_count_core`

## Requirements
- R1: After reset, the count is 0, the counter is not running (`IDLE`), and both event pulses are low.
- R2: The count advances by exactly 1 on the clock edge that follows a cycle in which the counter is running and `tick_i` is 1. In every other cycle without a clear or a wrap, the count holds its value.
- R3: When `clr_i` is 1, the count is 0 after the next edge, whatever `tick_i` and the run state are. A clear never raises `match_o` or `ovf_o`.
- R4: When a counting tick arrives while the count equals `period_i`, the count becomes 0 and `match_o` is 1 for that one following cycle.
- R5: When a counting tick arrives at count 0xFFFF and `period_i` differs from 0xFFFF, the count becomes 0 and `ovf_o` is 1 for one cycle.
- R6: When `period_i` is 0xFFFF, reaching it raises `match_o` only. `match_o` and `ovf_o` are never 1 together.
- R7: With `oneshot_i` = 0 (repeat mode), the counter stays running across a match, an overflow, or a clear.
- R8: With `oneshot_i` = 1 (one-shot mode), `running_o` goes to 0 on the same edge as a match, an overflow, or a clear that occurs while running (`ONESHOT_END`).
- R9: A `start_i` pulse in `IDLE` without `stop_i` makes `running_o` 1 after the next edge (`START`). A `stop_i` pulse always leaves `running_o` at 0 after the next edge (`STOP`), and it wins over `start_i`.
- R10: A tick that coincides with `stop_i` in `RUN` is still counted. A tick that coincides with `start_i` in `IDLE` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop pulse |
| clr_i | input | 1 | Software clear strobe; forces the count to 0 |
| oneshot_i | input | 1 | Mode: 0 = repeat, 1 = one-shot |
| tick_i | input | 1 | Count-enable pulse |
| period_i | input | 16 | Period compare value |
| count_o | output | 16 | Current count |
| running_o | output | 1 | 1 while in `RUN` |
| match_o | output | 1 | One-cycle period-match pulse |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The overflow wrap is the hardest case to reach. The period compare normally clears the count long before 0xFFFF. To get there, the bench first raises the count above a small period, using a large period to do so. It then lowers the period below the count and feeds about 65 000 ticks. At that point the count has passed the compare value and must wrap. A second long run, with the period set to 0xFFFF, checks that the match wins over the overflow at the top value. Short random runs with small periods cover the start, stop, clear and mode interleavings.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic oneshot_i,
    input  logic end_evt_i,
    output logic running_o
);
    run_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start_i && !stop_i) state_d = S_RUN;         // START
            S_RUN: begin
                if (stop_i)                       state_d = S_IDLE;  // STOP
                else if (oneshot_i && end_evt_i)  state_d = S_IDLE;  // ONESHOT_END
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb running_o = (state_q == S_RUN);

    // R9: stop always leaves the machine idle
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !running_o);
    // R7: repeat mode leaves only through stop
    a_r7_repeat_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !oneshot_i && !stop_i) |=> running_o);
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] period_i,
    output logic [WIDTH-1:0] count_o,
    output logic             match_o,
    output logic             ovf_o,
    output logic             end_evt_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic adv, hit, at_top;
    always_comb begin
        adv       = run_i && tick_i && !clr_i;
        hit       = (count_o == period_i);
        at_top    = (count_o == TOP);
        end_evt_o = clr_i || (adv && (hit || at_top));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
            match_o <= 1'b0;
            ovf_o   <= 1'b0;
        end else begin
            match_o <= 1'b0;
            ovf_o   <= 1'b0;
            if (clr_i) begin
                count_o <= '0;
            end else if (adv) begin
                if (hit) begin
                    count_o <= '0;
                    match_o <= 1'b1;
                end else if (at_top) begin
                    count_o <= '0;
                    ovf_o   <= 1'b1;
                end else begin
                    count_o <= count_o + 1'b1;
                end
            end
        end
    end

    // R3: clear strobe zeroes the count with no event
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0 && !match_o && !ovf_o));
    // R4: a match pulse always lands on a zero count
    a_r4_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (count_o == '0));
    // R5: overflow only follows the top value
    a_r5_ovf_from_top: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(count_o) == TOP && count_o == '0));
    // R6: never both events
    a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && ovf_o));
    // R2: no run or no tick means the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(run_i && tick_i)) |=> $stable(count_o));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clr_i,
    input  logic             oneshot_i,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] period_i,
    output logic [WIDTH-1:0] count_o,
    output logic             running_o,
    output logic             match_o,
    output logic             ovf_o
);
    logic end_evt;

    tmr_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .oneshot_i (oneshot_i),
        .end_evt_i (end_evt),
        .running_o (running_o)
    );

    tmr_count_reg #(.WIDTH(WIDTH)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (running_o),
        .tick_i    (tick_i),
        .clr_i     (clr_i),
        .period_i  (period_i),
        .count_o   (count_o),
        .match_o   (match_o),
        .ovf_o     (ovf_o),
        .end_evt_o (end_evt)
    );

    // R8: one-shot halts on the edge that produces an event
    a_r8_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(oneshot_i) && (match_o || ovf_o)) |-> !running_o);
endmodule

// File: tb/tmr_count_core_test.sv
module tmr_count_core_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, clr_i = 0, oneshot_i = 0, tick_i = 0;
    logic [15:0] period_i = 16'd10;
    logic [15:0] count_o;
    logic running_o, match_o, ovf_o;

    int total = 0;
    int bad = 0;
    logic [15:0] m_cnt = 0;
    logic m_run = 0, m_mt = 0, m_ov = 0;

    always #5 clk = ~clk;

    tmr_count_core uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .clr_i(clr_i), .oneshot_i(oneshot_i), .tick_i(tick_i),
        .period_i(period_i), .count_o(count_o), .running_o(running_o),
        .match_o(match_o), .ovf_o(ovf_o)
    );

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " count"}, count_o == m_cnt, count_o, m_cnt);
        check({tag, " running"}, running_o == m_run, running_o, m_run);
        check({tag, " match"}, match_o == m_mt, match_o, m_mt);
        check({tag, " ovf"}, ovf_o == m_ov, ovf_o, m_ov);
    endtask

    // reference model of one clock edge
    task automatic model_step();
        logic fin;
        fin  = 0;
        m_mt = 0;
        m_ov = 0;
        if (clr_i) begin
            m_cnt = 0;
            fin   = 1;
        end else if (m_run && tick_i) begin
            if (m_cnt == period_i) begin
                m_cnt = 0; m_mt = 1; fin = 1;
            end else if (m_cnt == 16'hFFFF) begin
                m_cnt = 0; m_ov = 1; fin = 1;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (!m_run)         m_run = start_i && !stop_i;
        else if (stop_i)    m_run = 0;
        else if (oneshot_i && fin) m_run = 0;
    endtask

    task automatic cyc(input logic st, input logic sp, input logic cl, input logic tk,
                       input bit chk, input string tag);
        @(negedge clk);
        start_i = st; stop_i = sp; clr_i = cl; tick_i = tk;
        model_step();
        @(posedge clk);
        #2;
        if (chk) compare_all(tag);
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1 reset");
        @(negedge clk);
        rst_n = 1;

        // R9 start, R2 counting
        cyc(1, 0, 0, 1, 1, "R10 start with tick not counted");
        cyc(0, 0, 0, 1, 1, "R2 count 1");
        cyc(0, 0, 0, 0, 1, "R2 hold without tick");
        cyc(0, 0, 0, 1, 1, "R2 count 2");
        cyc(0, 0, 1, 1, 1, "R3 clear beats tick");
        cyc(0, 0, 0, 1, 1, "R7 repeat survives clear");
        cyc(0, 1, 0, 1, 1, "R10 stop tick counted");
        cyc(1, 1, 0, 0, 1, "R9 stop wins over start");
        // R4 match in repeat
        period_i = 16'd3;
        cyc(1, 0, 0, 0, 1, "R9 start");
        repeat (5) cyc(0, 0, 0, 1, 1, "R4 match/R7 repeat");
        // R8 one-shot on match and on clear
        oneshot_i = 1;
        repeat (6) cyc(0, 0, 0, 1, 1, "R8 one-shot match end");
        cyc(1, 0, 0, 0, 1, "R9 restart");
        cyc(0, 0, 0, 1, 1, "R2 one-shot count");
        cyc(0, 0, 1, 0, 1, "R8 one-shot clear end");
        oneshot_i = 0;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 97 == 0) begin
                period_i  = 16'($urandom_range(0, 12));
                oneshot_i = r[20];
            end
            cyc(r[3:0] == 0, r[7:4] == 0, r[11:8] == 0, r[12] | r[13], 1, "R2 R4 R8 random");
        end

        // R5: push count above a small period, then wrap through 0xFFFF
        oneshot_i = 0;
        period_i  = 16'hFFFF;
        cyc(0, 0, 1, 0, 1, "R3 clear before wrap");
        cyc(1, 0, 0, 0, 1, "R9 start before wrap");
        repeat (20) cyc(0, 0, 0, 1, 0, "");
        period_i = 16'd5;
        while (m_cnt != 16'hFFFF) cyc(0, 0, 0, 1, 0, "");
        compare_all("R5 at top");
        cyc(0, 0, 0, 1, 1, "R5 overflow wrap");
        check("R5 ovf pulse", ovf_o == 1'b1, ovf_o, 1);
        cyc(0, 0, 0, 1, 1, "R5 pulse one cycle");

        // R6: period at top, one-shot
        period_i  = 16'hFFFF;
        oneshot_i = 1;
        cyc(0, 0, 1, 0, 1, "R3 clear");
        cyc(1, 0, 0, 0, 1, "R9 start");
        while (m_cnt != 16'hFFFF) cyc(0, 0, 0, 1, 0, "");
        compare_all("R6 at top");
        cyc(0, 0, 0, 1, 1, "R6 match not ovf");
        check("R6 match only", match_o && !ovf_o, {match_o, ovf_o}, 2'b10);
        check("R8 one-shot stops after top", running_o == 1'b0, running_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1900000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule